// File: doc/BRIEF.md
# Parallel Adapter Register Access Sequencer

This block runs single-register transfers from the host side of a parallel port to a disk register file that sits behind an adapter. Each transfer is a fixed series of steps on the port. Every step sets the control lines and the data lines and then holds them. The steps are an address phase and then either a write phase or a read phase. The block supports two port modes. In nibble mode, reads arrive as two 4-bit halves on the status lines and writes are full bytes. In byte mode, transfers are 8 bits in both directions.

A client pulses `req_i` with the operation, a register-set select bit, a 3-bit register number and, for a write, the data. The block drives the port through the whole sequence. At the end it raises `done_o` for one clock and, for a read, updates `rdata_o`. Every step lasts `step_len_i + 1` clocks, so slow adapters can be met without changing the sequence.

Top module: `pport_reg_seq`

## Requirements
- R1: After reset, ctl_o = 04h, pd_o = 00h, pd_oe_o = 1, done_o = 0 and rdata_o = 00h.
- R2: Every transfer opens with 16 steps: data 01h with control 05h,0Dh,05h,0Dh,05h,04h; then the address code with control 05h,07h,05h,04h; then data 00h with control 05h,0Dh,05h,0Dh,05h,04h.
- R3: The address code on pd_o equals reg_i*4 + 1 + sel_i. sel_i = 0 picks the task register file and sel_i = 1 picks the control register set.
- R4: A write adds 8 steps after the address phase. The data lines carry wdata_i in all 8 steps, and the control lines run 05h,07h,05h,04h twice, for 24 steps in total.
- R5: A nibble-mode read adds 8 steps with control 06h,04h repeated four times and data 00h. Status is sampled on the last clock of the first and the second 06h step, and rdata_o = {second[7:4], first[7:4]}.
- R6: A byte-mode read (byte_mode_i = 1) adds 4 steps with control 26h,04h,26h,04h. pd_i is sampled on the last clock of the first 26h step and becomes rdata_o. The 20 steps ignore the value on pd_i during the second 26h step.
- R7: pd_oe_o is 0 exactly during the 26h steps of a byte-mode read and is 1 at all other times.
- R8: Each step holds for step_len_i + 1 clocks. The value of step_len_i is taken when the request is accepted.
- R9: done_o is high for exactly one clock, in the clock after the last step. In that same clock ctl_o = 04h, pd_o = 00h and pd_oe_o = 1.
- R10: A request that arrives while a transfer is running is ignored. It is not queued. The operands are captured when a request is accepted, so changing the inputs later has no effect.
- R11: A write leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transfer (accepted only when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 1 | Register-set select |
| reg_i | input | 3 | Register number |
| wdata_i | input | 8 | Write data |
| byte_mode_i | input | 1 | 0 = nibble mode, 1 = byte mode |
| step_len_i | input | HOLD_W | Extra hold clocks per step |
| status_i | input | 8 | Port status lines |
| pd_i | input | 8 | Data lines, read direction |
| pd_o | output | 8 | Data lines, drive value |
| pd_oe_o | output | 1 | Data line drive enable |
| ctl_o | output | 6 | Control lines |
| rdata_o | output | 8 | Read result |
| done_o | output | 1 | Transfer finished (one clock pulse) |

## Verification
The hardest case is a clean separation of the two sampling points from the steps around them. In a nibble read the 06h toggles that follow the samples must not disturb the result. In a byte read the second 26h step must not either. The bench drives a different junk value on status and pd_i in every step except the intended sampling steps, so a sample taken one step early or late gives a wrong byte. Requests that arrive mid-transfer, with new operands and a new hold length, are injected part-way through chosen transfers. The full cycle trace and the idle clocks that follow are then compared.

// File: rtl/pport_seq_pkg.sv
package pport_seq_pkg;
  localparam int unsigned IDX_W = 5;
  localparam logic [5:0] CTL_IDLE = 6'h04;

  typedef enum logic [1:0] {SMP_NONE, SMP_LO, SMP_HI, SMP_BYTE} smp_e;

  typedef struct packed {
    logic [5:0] ctl;
    logic [7:0] data;
    logic       drive;
    smp_e       smp;
    logic       last;
  } step_t;
endpackage

// File: rtl/pport_step_decode.sv
module pport_step_decode
  import pport_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wr_i,
  input  logic             byte_mode_i,
  input  logic [7:0]       code_i,
  input  logic [7:0]       wdata_i,
  output step_t            step_o
);
  function automatic logic [5:0] long_pulse(input logic [2:0] k);
    case (k)
      3'd1, 3'd3: long_pulse = 6'h0d;
      3'd5:       long_pulse = 6'h04;
      default:    long_pulse = 6'h05;
    endcase
  endfunction

  function automatic logic [5:0] short_pulse(input logic [1:0] k);
    case (k)
      2'd1:    short_pulse = 6'h07;
      2'd3:    short_pulse = 6'h04;
      default: short_pulse = 6'h05;
    endcase
  endfunction

  logic [IDX_W-1:0] rel_a, rel_c, rel_t;
  assign rel_a = idx_i - 5'd6;
  assign rel_c = idx_i - 5'd10;
  assign rel_t = idx_i - 5'd16;

  always_comb begin
    step_o       = '0;
    step_o.drive = 1'b1;
    step_o.smp   = SMP_NONE;
    if (idx_i < 5'd6) begin
      step_o.data = 8'h01;
      step_o.ctl  = long_pulse(idx_i[2:0]);
    end else if (idx_i < 5'd10) begin
      step_o.data = code_i;
      step_o.ctl  = short_pulse(rel_a[1:0]);
    end else if (idx_i < 5'd16) begin
      step_o.ctl  = long_pulse(rel_c[2:0]);
    end else if (wr_i) begin
      step_o.data = wdata_i;
      step_o.ctl  = short_pulse(rel_t[1:0]);
      step_o.last = (idx_i == 5'd23);
    end else if (byte_mode_i) begin
      step_o.ctl   = idx_i[0] ? 6'h04 : 6'h26;
      step_o.drive = idx_i[0];
      step_o.smp   = (idx_i == 5'd16) ? SMP_BYTE : SMP_NONE;
      step_o.last  = (idx_i == 5'd19);
    end else begin
      step_o.ctl  = idx_i[0] ? 6'h04 : 6'h06;
      step_o.smp  = (idx_i == 5'd16) ? SMP_LO :
                    (idx_i == 5'd18) ? SMP_HI : SMP_NONE;
      step_o.last = (idx_i == 5'd23);
    end
  end
endmodule

// File: rtl/pport_step_timer.sv
module pport_step_timer
  import pport_seq_pkg::*;
#(
  parameter int unsigned HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] len_i,
  input  logic              last_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              step_end_o,
  output logic              fin_o
);
  logic [HOLD_W-1:0] cnt_q, len_q;

  assign step_end_o = busy_o && (cnt_q == '0);
  assign fin_o      = step_end_o && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        idx_o  <= '0;
        cnt_q  <= len_i;
        len_q  <= len_i;
      end
    end else if (step_end_o) begin
      if (last_i) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
        cnt_q <= len_q;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q <= len_q);
  // R8
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (idx_o == $past(idx_o) || idx_o == $past(idx_o) + 1'b1));
endmodule

// File: rtl/pport_rd_capture.sv
module pport_rd_capture
  import pport_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_end_i,
  input  smp_e       smp_i,
  input  logic       fin_i,
  input  logic       wr_i,
  input  logic       byte_mode_i,
  input  logic [7:0] status_i,
  input  logic [7:0] pd_i,
  output logic [7:0] rdata_o,
  output logic       done_o
);
  logic [3:0] lo_q, hi_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      byte_q  <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (step_end_i) begin
        case (smp_i)
          SMP_LO:   lo_q   <= status_i[7:4];
          SMP_HI:   hi_q   <= status_i[7:4];
          SMP_BYTE: byte_q <= pd_i;
          default:  ;
        endcase
      end
      if (fin_i && !wr_i)
        rdata_o <= byte_mode_i ? byte_q : {hi_q, lo_q};
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));
endmodule

// File: rtl/pport_reg_seq.sv
module pport_reg_seq
  import pport_seq_pkg::*;
#(
  parameter int unsigned HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [2:0]        reg_i,
  input  logic [7:0]        wdata_i,
  input  logic              byte_mode_i,
  input  logic [HOLD_W-1:0] step_len_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        pd_i,
  output logic [7:0]        pd_o,
  output logic              pd_oe_o,
  output logic [5:0]        ctl_o,
  output logic [7:0]        rdata_o,
  output logic              done_o
);
  logic             busy, step_end, fin, accept;
  logic [IDX_W-1:0] idx;
  logic             wr_q, byte_q;
  logic [7:0]       code_q, wdata_q;
  step_t            step;

  assign accept = req_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      code_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= wr_i;
      byte_q  <= byte_mode_i;
      code_q  <= {3'b000, reg_i, 2'b01} + {7'd0, sel_i};
      wdata_q <= wdata_i;
    end
  end

  pport_step_timer #(.HOLD_W(HOLD_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .len_i      (step_len_i),
    .last_i     (step.last),
    .busy_o     (busy),
    .idx_o      (idx),
    .step_end_o (step_end),
    .fin_o      (fin)
  );

  pport_step_decode i_decode (
    .idx_i       (idx),
    .wr_i        (wr_q),
    .byte_mode_i (byte_q),
    .code_i      (code_q),
    .wdata_i     (wdata_q),
    .step_o      (step)
  );

  pport_rd_capture i_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_end_i  (step_end),
    .smp_i       (step.smp),
    .fin_i       (fin),
    .wr_i        (wr_q),
    .byte_mode_i (byte_q),
    .status_i    (status_i),
    .pd_i        (pd_i),
    .rdata_o     (rdata_o),
    .done_o      (done_o)
  );

  assign ctl_o   = busy ? step.ctl   : CTL_IDLE;
  assign pd_o    = busy ? step.data  : 8'h00;
  assign pd_oe_o = busy ? step.drive : 1'b1;

  // R7
  oe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_oe_o |-> (ctl_o[5] && byte_q && !wr_q));
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy && ctl_o == CTL_IDLE && pd_oe_o));
  // R10
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(code_q) && $stable(wr_q) && $stable(wdata_q)));
endmodule

// File: tb/test_pport_reg_seq.sv
`timescale 1ns/1ps
module test_pport_reg_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, wr = 0, sel = 0, bm = 0;
  logic [2:0] rg = 0;
  logic [7:0] wd = 0, status = 0, pd_in = 0;
  logic [3:0] len = 0;
  logic [7:0] pdo, rdata;
  logic       oe, done;
  logic [5:0] ctl;
  int tests = 0, fails = 0;
  logic [7:0] last_rd = 8'h00;

  always #2.5 clk = ~clk;

  pport_reg_seq i_pport_reg_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .sel_i(sel),
    .reg_i(rg), .wdata_i(wd), .byte_mode_i(bm), .step_len_i(len),
    .status_i(status), .pd_i(pd_in), .pd_o(pdo), .pd_oe_o(oe),
    .ctl_o(ctl), .rdata_o(rdata), .done_o(done));

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // returns {oe, ctl, data} per the requirements
  function automatic logic [14:0] exp_step(bit w, bit b, logic [7:0] code, logic [7:0] wv, int s);
    int lp[6] = '{5, 13, 5, 13, 5, 4};
    int sp[4] = '{5, 7, 5, 4};
    if (s < 6)       return {1'b1, 6'(lp[s]), 8'h01};
    if (s < 10)      return {1'b1, 6'(sp[s-6]), code};
    if (s < 16)      return {1'b1, 6'(lp[s-10]), 8'h00};
    if (w)           return {1'b1, 6'(sp[(s-16)%4]), wv};
    if (b)           return (s % 2 == 0) ? {1'b0, 6'h26, 8'h00} : {1'b1, 6'h04, 8'h00};
    return (s % 2 == 0) ? {1'b1, 6'h06, 8'h00} : {1'b1, 6'h04, 8'h00};
  endfunction

  task automatic run(input bit w, input bit s, input logic [2:0] r, input logic [7:0] wv,
                     input bit b, input logic [3:0] l, input bit poke);
    logic [7:0] code = {3'b000, r, 2'b00} + 8'd1 + {7'd0, s};
    logic [7:0] rv = 8'((r * 37 + s * 91 + l * 13 + wv) & 255);
    int n = w ? 24 : (b ? 20 : 24);
    int span = n * (l + 1);
    int bad = 0, oe_low = 0;
    logic [14:0] e;
    logic [7:0] code_seen = 8'hxx;
    logic [7:0] exp_rd;
    @(negedge clk);
    req = 1; wr = w; sel = s; rg = r; wd = wv; bm = b; len = l;
    @(negedge clk);
    req = 0;
    if (poke) begin wr = ~w; sel = ~s; rg = ~r; wd = ~wv; bm = ~b; len = l + 4'd2; end
    for (int k = 0; k < span; k++) begin
      int st = k / (l + 1);
      if (poke && k == 2) req = 1;
      if (poke && k == 3) req = 0;
      status = (st == 16) ? {rv[3:0], 4'ha} : (st == 18) ? {rv[7:4], 4'h5} : 8'(st * 29 + 7);
      pd_in  = (st == 16) ? rv : (st == 18) ? ~rv : 8'(st * 53 + 3);
      e = exp_step(w, b, code, wv, st);
      if ({oe, ctl, pdo} !== e) begin
        if (bad == 0) $display("FAIL R2 R4 R5 R6 R8 step %0d actual=%0h expected=%0h", st, {oe, ctl, pdo}, e);
        bad++;
      end
      if (st == 7) code_seen = pdo;
      if (!oe) oe_low++;
      if (done) bad++;
      @(negedge clk);
    end
    tests++; if (bad != 0) fails++;  // R2 R4 R5 R6 R8 trace
    check(code_seen === code, "R3 address code", code_seen, code);
    check(oe_low == ((!w && b) ? 2 * (l + 1) : 0), "R7 drive-off clocks", oe_low, (!w && b) ? 2 * (l + 1) : 0);
    exp_rd = w ? last_rd : rv;
    check(done === 1'b1 && ctl == 6'h04 && pdo == 8'h00 && oe, "R9 done with idle lines", {done, ctl}, 7'h44);
    check(rdata === exp_rd, w ? "R11 rdata after write" : (b ? "R6 byte read" : "R5 nibble read"), rdata, exp_rd);
    last_rd = exp_rd;
    @(negedge clk);
    check(done === 1'b0 && ctl == 6'h04, poke ? "R10 no queued request" : "R9 single pulse", {done, ctl}, 7'h04);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ctl == 6'h04 && pdo == 8'h00 && oe && !done && rdata == 8'h00, "R1 reset state",
          {ctl, pdo, oe, done, rdata}, {6'h04, 8'h00, 1'b1, 1'b0, 8'h00});
    rst_n = 1;
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 2; s++)
        for (int r = 0; r < 8; r++)
          run(m == 0, s[0], 3'(r), 8'(r * 17 + s * 100 + m * 7 + 1), m == 2,
              4'((r + s) % 3), r == 5);
    run(1'b0, 1'b1, 3'd7, 8'h5a, 1'b0, 4'd15, 1'b0);  // R8 long hold
    run(1'b1, 1'b0, 3'd3, 8'hc3, 1'b1, 4'd15, 1'b1);  // R10 R11
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule